// File: doc/BRIEF.md
# Address-Encoded Read Wait-State Injector

This block sits on an AHB-Lite read/write path in front of a flash controller that owns a page read buffer. It lets a read take longer on purpose, so that code running from flash sees the access timing of another memory. A calibration overlay is the typical case. A five-bit delay field taken from the upper address bits (`haddr[28:24]` by default) holds the number of extra wait states. When the field is zero, the block adds nothing and the flash controller answers at its own pace.

Only the first beat of a read carries the extra delay. That beat is either the NONSEQ beat that opens a burst or a lone single read. SEQ beats and all writes go through without added cycles. While the data phase of a read with a non-zero field is in progress, the block raises two plain control pins toward the flash controller. One stops the page buffer from starting a prefetch. The other makes the controller ignore a buffer hit and fetch from the array.

The flash side is a valid/ready port. `fl_valid` rises once the injected wait states are over. `fl_valid`, `fl_addr` and `fl_write` stay unchanged until the flash accepts the request with `fl_ready`. The flash controller applies back-pressure by keeping `fl_ready` low. Back-pressure passes straight back to the bus master as a low `hreadyout`, and the data phase completes in the cycle in which the request is accepted.

Top module: `ws_inject`

## Requirements
- R1: A NONSEQ read whose delay field (`haddr[28:24]`) holds N (0..31) keeps `fl_valid` low for exactly N cycles after the address phase. With `fl_ready` high, `hreadyout` is low for N cycles and high in cycle N+1.
- R2: A NONSEQ read with a zero delay field raises `fl_valid` in the first data-phase cycle.
- R3: A write (`hwrite`=1) raises `fl_valid` in the first data-phase cycle, whatever its delay field holds.
- R4: A SEQ beat (`htrans`=2'b11) raises `fl_valid` in the first data-phase cycle, whatever its delay field holds.
- R5: `pf_inhibit` and `hit_ignore` are both high during the whole data phase of any read, NONSEQ or SEQ, whose delay field is non-zero. They are low when the block is idle and during writes and zero-field reads.
- R6: Once raised, `fl_valid` stays high with `fl_addr` and `fl_write` unchanged until `fl_ready` is seen high. The data phase ends (`hreadyout`=1) in exactly that cycle.
- R7: `hrdata` follows `fl_rdata` and `fl_wdata` follows `hwdata` without delay.
- R8: The address is sampled only when `hsel`, `htrans[1]` and `hready` are high together. The field of a transfer presented during a stalled data phase has no effect on that phase's length.
- R9: After reset, `hreadyout` is high and `fl_valid`, `pf_inhibit` and `hit_ignore` are low.
- R10: `hresp` is always OKAY (0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hsel | input | 1 | Slave select |
| haddr | input | AW | Transfer address; bits [FLD_LSB+FLD_W-1:FLD_LSB] hold the delay field |
| htrans | input | 2 | Transfer type: IDLE 00, BUSY 01, NONSEQ 10, SEQ 11 |
| hwrite | input | 1 | 1 = write, 0 = read |
| hready | input | 1 | Bus-wide ready; ends the previous data phase |
| hwdata | input | DW | Write data |
| hreadyout | output | 1 | Data phase complete |
| hrdata | output | DW | Read data |
| hresp | output | 1 | Response, always OKAY |
| fl_valid | output | 1 | Request to the flash is valid |
| fl_ready | input | 1 | Flash accepts/completes the request |
| fl_addr | output | AW | Captured address of the current transfer |
| fl_write | output | 1 | Captured direction of the current transfer |
| fl_wdata | output | DW | Write data to the flash |
| fl_rdata | input | DW | Read data from the flash |
| pf_inhibit | output | 1 | Do not start a page-buffer prefetch |
| hit_ignore | output | 1 | Ignore page-buffer hits; access the array |

## Verification
The assertions assume that the master obeys AHB-Lite pipelining: an address phase stays unchanged while `hready` is low, and `hready` is the block's own `hreadyout`, since it is the only slave. They also assume that the flash controller never takes a request before `fl_valid` is high.

The stimulus meets these assumptions as follows. `hready` is tied to `hreadyout`. A new address is driven only after the bench's model has seen the previous one accepted. `fl_ready` toggles freely, which stays within the valid/ready rules. Delay fields mix the extremes 0, 1 and 31 with small values.

// File: rtl/ws_inject_pkg.sv
package ws_inject_pkg;
  typedef enum logic [1:0] {
    HT_IDLE   = 2'b00,
    HT_BUSY   = 2'b01,
    HT_NONSEQ = 2'b10,
    HT_SEQ    = 2'b11
  } htrans_e;
endpackage

// File: rtl/ws_addr_phase.sv
module ws_addr_phase
  import ws_inject_pkg::*;
#(
  parameter int AW      = 32,
  parameter int FLD_LSB = 24,
  parameter int FLD_W   = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hsel,
  input  logic [AW-1:0]    haddr,
  input  logic [1:0]       htrans,
  input  logic             hwrite,
  input  logic             hready,
  output logic             acc,
  output logic [FLD_W-1:0] load_val,
  output logic [AW-1:0]    cap_addr,
  output logic             cap_write,
  output logic             cap_emu
);
  logic [FLD_W-1:0] fld;
  logic             first_beat;
  logic             emu_now;

  assign fld        = haddr[FLD_LSB +: FLD_W];
  assign acc        = hsel & htrans[1] & hready;
  assign first_beat = (htrans == HT_NONSEQ);
  assign emu_now    = !hwrite && (fld != '0);
  assign load_val   = (!hwrite && first_beat) ? fld : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_addr  <= '0;
      cap_write <= 1'b0;
      cap_emu   <= 1'b0;
    end else if (acc) begin
      cap_addr  <= haddr;
      cap_write <= hwrite;
      cap_emu   <= emu_now;
    end
  end
endmodule

// File: rtl/ws_wait_ctr.sv
module ws_wait_ctr #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (load)         cnt <= load_val;
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/ws_phase_ctl.sv
module ws_phase_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic acc,
  input  logic expired,
  input  logic fl_ready,
  input  logic cap_emu,
  output logic active,
  output logic hreadyout,
  output logic fl_valid,
  output logic pf_inhibit,
  output logic hit_ignore
);
  assign fl_valid   = active & expired;
  assign hreadyout  = !active | (expired & fl_ready);
  assign pf_inhibit = active & cap_emu;
  assign hit_ignore = active & cap_emu;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         active <= 1'b0;
    else if (acc)       active <= 1'b1;
    else if (hreadyout) active <= 1'b0;
  end
endmodule

// File: rtl/ws_inject.sv
module ws_inject #(
  parameter int AW      = 32,
  parameter int DW      = 32,
  parameter int FLD_LSB = 24,
  parameter int FLD_W   = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hsel,
  input  logic [AW-1:0] haddr,
  input  logic [1:0]    htrans,
  input  logic          hwrite,
  input  logic          hready,
  input  logic [DW-1:0] hwdata,
  output logic          hreadyout,
  output logic [DW-1:0] hrdata,
  output logic          hresp,
  output logic          fl_valid,
  input  logic          fl_ready,
  output logic [AW-1:0] fl_addr,
  output logic          fl_write,
  output logic [DW-1:0] fl_wdata,
  input  logic [DW-1:0] fl_rdata,
  output logic          pf_inhibit,
  output logic          hit_ignore
);
  logic             acc;
  logic [FLD_W-1:0] load_val;
  logic             cap_emu;
  logic             expired;
  logic             active;

  ws_addr_phase #(.AW(AW), .FLD_LSB(FLD_LSB), .FLD_W(FLD_W)) u_addr (
    .clk(clk), .rst_n(rst_n), .hsel(hsel), .haddr(haddr), .htrans(htrans),
    .hwrite(hwrite), .hready(hready), .acc(acc), .load_val(load_val),
    .cap_addr(fl_addr), .cap_write(fl_write), .cap_emu(cap_emu)
  );

  ws_wait_ctr #(.W(FLD_W)) u_ctr (
    .clk(clk), .rst_n(rst_n), .load(acc), .load_val(load_val),
    .expired(expired)
  );

  ws_phase_ctl u_ctl (
    .clk(clk), .rst_n(rst_n), .acc(acc), .expired(expired),
    .fl_ready(fl_ready), .cap_emu(cap_emu), .active(active),
    .hreadyout(hreadyout), .fl_valid(fl_valid),
    .pf_inhibit(pf_inhibit), .hit_ignore(hit_ignore)
  );

  assign hrdata   = fl_rdata;
  assign fl_wdata = hwdata;
  assign hresp    = 1'b0;
endmodule

// File: rtl/ws_inject_chk.sv
module ws_inject_chk #(
  parameter int AW      = 32,
  parameter int FLD_LSB = 24,
  parameter int FLD_W   = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          hsel,
  input logic [AW-1:0] haddr,
  input logic [1:0]    htrans,
  input logic          hwrite,
  input logic          hready,
  input logic          hreadyout,
  input logic          fl_valid,
  input logic          fl_ready,
  input logic [AW-1:0] fl_addr,
  input logic          fl_write,
  input logic          pf_inhibit,
  input logic          hit_ignore
);
  logic             c_acc;
  logic [FLD_W-1:0] c_fld;
  logic             trk;
  logic [FLD_W-1:0] trk_exp;
  logic [FLD_W:0]   trk_run;

  assign c_acc = hsel && htrans[1] && hready;
  assign c_fld = haddr[FLD_LSB +: FLD_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trk     <= 1'b0;
      trk_exp <= '0;
      trk_run <= '0;
    end else if (c_acc) begin
      trk     <= !hwrite && (htrans == 2'b10);
      trk_exp <= c_fld;
      trk_run <= '0;
    end else if (trk && !fl_valid) begin
      trk_run <= trk_run + 1'b1;
    end else if (trk && fl_valid) begin
      trk <= 1'b0;
    end
  end

  // R1: injected window length equals the field value
  a_r1_wait_len: assert property (@(posedge clk) disable iff (!rst_n)
    (trk && fl_valid) |-> (trk_run == {1'b0, trk_exp}));

  a_r1_wait_low: assert property (@(posedge clk) disable iff (!rst_n)
    (c_acc && !hwrite && htrans == 2'b10 && c_fld != '0) |=> (!fl_valid && !hreadyout));

  a_r2_zero_field: assert property (@(posedge clk) disable iff (!rst_n)
    (c_acc && !hwrite && c_fld == '0) |=> fl_valid);

  a_r3_write_nowait: assert property (@(posedge clk) disable iff (!rst_n)
    (c_acc && hwrite) |=> fl_valid);

  a_r4_seq_nowait: assert property (@(posedge clk) disable iff (!rst_n)
    (c_acc && htrans == 2'b11) |=> fl_valid);

  a_r5_flags_on: assert property (@(posedge clk) disable iff (!rst_n)
    (c_acc && !hwrite && c_fld != '0) |=> (pf_inhibit && hit_ignore));

  a_r5_flags_off: assert property (@(posedge clk) disable iff (!rst_n)
    (c_acc && (hwrite || c_fld == '0)) |=> (!pf_inhibit && !hit_ignore));

  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_valid && !fl_ready) |=> (fl_valid && $stable(fl_addr) && $stable(fl_write)));

  a_r6_done: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_valid && fl_ready) |-> hreadyout);
endmodule

bind ws_inject ws_inject_chk #(.AW(AW), .FLD_LSB(FLD_LSB), .FLD_W(FLD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .hsel(hsel), .haddr(haddr), .htrans(htrans),
  .hwrite(hwrite), .hready(hready), .hreadyout(hreadyout),
  .fl_valid(fl_valid), .fl_ready(fl_ready), .fl_addr(fl_addr),
  .fl_write(fl_write), .pf_inhibit(pf_inhibit), .hit_ignore(hit_ignore)
);

// File: tb/test_ws_inject.sv
module test_ws_inject;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          hsel = 1'b0;
  logic [AW-1:0] haddr = '0;
  logic [1:0]    htrans = 2'b00;
  logic          hwrite = 1'b0;
  logic          hready;
  logic [DW-1:0] hwdata = '0;
  logic          hreadyout;
  logic [DW-1:0] hrdata;
  logic          hresp;
  logic          fl_valid;
  logic          fl_ready = 1'b1;
  logic [AW-1:0] fl_addr;
  logic          fl_write;
  logic [DW-1:0] fl_wdata;
  logic [DW-1:0] fl_rdata = '0;
  logic          pf_inhibit;
  logic          hit_ignore;

  assign hready = hreadyout;

  ws_inject i_ws_inject (
    .clk(clk), .rst_n(rst_n), .hsel(hsel), .haddr(haddr), .htrans(htrans),
    .hwrite(hwrite), .hready(hready), .hwdata(hwdata), .hreadyout(hreadyout),
    .hrdata(hrdata), .hresp(hresp), .fl_valid(fl_valid), .fl_ready(fl_ready),
    .fl_addr(fl_addr), .fl_write(fl_write), .fl_wdata(fl_wdata),
    .fl_rdata(fl_rdata), .pf_inhibit(pf_inhibit), .hit_ignore(hit_ignore)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit done = 0;
  bit directed = 1;
  bit rnd_mode = 0;

  // reference model state
  bit          m_act = 0;
  int          m_cnt = 0;
  int          m_load = 0;
  int          m_fld = 0;
  bit          m_wr = 0;
  bit          m_seq = 0;
  logic [AW-1:0] m_addr = '0;
  bit          last_ro = 1;
  int          low_cnt = 0;

  task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  function automatic bit e_ro();
    return !m_act || (m_cnt == 0 && fl_ready);
  endfunction

  function automatic string ro_tag();
    if (m_wr) return "R3 write ready";
    if (m_seq) return "R4 seq ready";
    if (m_fld == 0) return "R2 zero-field ready";
    return "R1 wait ready";
  endfunction

  // model update at the active edge
  always @(posedge clk) begin
    if (!rst_n) begin
      m_act = 0; m_cnt = 0; last_ro = 1;
    end else begin
      bit ro;
      bit acc;
      ro  = e_ro();
      acc = hsel && htrans[1] && ro;
      last_ro = ro;
      if (acc) begin
        m_act  = 1;
        m_wr   = hwrite;
        m_seq  = (htrans == 2'b11);
        m_addr = haddr;
        m_fld  = int'(haddr[28:24]);
        m_cnt  = (!hwrite && htrans == 2'b10) ? m_fld : 0;
        m_load = m_cnt;
      end else if (ro) begin
        m_act = 0;
      end else if (m_cnt > 0) begin
        m_cnt--;
      end
    end
  end

  // compare away from the edge
  always @(negedge clk) begin
    #2;
    if (!done) begin
      if (!rst_n) begin
        chk(hreadyout, 1'b1, "R9 reset hreadyout");
        chk(fl_valid, 1'b0, "R9 reset fl_valid");
        chk({pf_inhibit, hit_ignore}, 2'b00, "R9 reset flags");
      end else begin
        bit ef;
        ef = m_act && !m_wr && m_fld != 0;
        chk(hreadyout, e_ro(), ro_tag());
        chk(fl_valid, m_act && m_cnt == 0, "R6 fl_valid");
        if (m_act) begin
          chk(fl_addr, m_addr, "R6 fl_addr");
          chk(fl_write, m_wr, "R6 fl_write");
        end
        chk(pf_inhibit, ef, "R5 pf_inhibit");
        chk(hit_ignore, ef, "R5 hit_ignore");
        chk(hrdata, fl_rdata, "R7 hrdata");
        chk(fl_wdata, hwdata, "R7 fl_wdata");
        chk(hresp, 1'b0, "R10 hresp");
        if (m_act && hreadyout) begin
          if (directed) chk(low_cnt, m_load, "R8 R1 wait length per phase");
          low_cnt = 0;
        end else if (m_act) begin
          low_cnt++;
        end else begin
          low_cnt = 0;
        end
      end
    end
  end

  task automatic issue(input bit sel, input logic [1:0] tr, input bit wr, input int fld);
    @(negedge clk);
    while (!last_ro) @(negedge clk);
    hsel   = sel;
    htrans = tr;
    hwrite = wr;
    haddr  = {$urandom()} & 32'hE0FF_FFFC;
    haddr[28:24] = fld[4:0];
  endtask

  always @(negedge clk) begin
    hwdata   <= $urandom();
    fl_rdata <= $urandom();
    if (rnd_mode) fl_ready <= ($urandom() % 4) != 0;
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  always @(posedge clk) cycles++;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // directed: R1 R2 R3 R4 R8 with fl_ready high
    issue(1, 2'b10, 0, 5);
    issue(1, 2'b10, 0, 2);   // presented during the 5-cycle wait (R8)
    issue(1, 2'b11, 0, 2);   // SEQ beat, no wait (R4)
    issue(1, 2'b10, 1, 31);  // write, no wait (R3)
    issue(1, 2'b10, 0, 0);   // zero field (R2)
    issue(1, 2'b10, 0, 31);  // max field (R1)
    issue(1, 2'b11, 0, 31);
    issue(0, 2'b10, 0, 7);   // not selected, ignored (R8)
    issue(1, 2'b01, 0, 7);   // BUSY, ignored (R8)
    issue(1, 2'b10, 0, 1);
    issue(1, 2'b00, 0, 0);
    repeat (40) @(negedge clk);
    // random phase with flash back-pressure
    directed = 0;
    rnd_mode = 1;
    for (int i = 0; i < 3000; i++) begin
      int  k;
      int  f;
      logic [1:0] tr;
      k = $urandom() % 8;
      case ($urandom() % 5)
        0: f = 0;
        1: f = 1;
        2: f = 31;
        default: f = $urandom() % 6;
      endcase
      tr = (k == 0) ? 2'b00 : (k == 1) ? 2'b01 : (k < 5) ? 2'b10 : 2'b11;
      issue(($urandom() % 8) != 0, tr, ($urandom() % 3) == 0, f);
    end
    issue(0, 2'b00, 0, 0);
    rnd_mode = 0;
    fl_ready = 1'b1;
    repeat (50) @(negedge clk);
    #3;
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule